// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side command sequencer for the erase functions of a parallel NOR flash. It watches single-cycle write strobes, each carrying an address and a data byte, and recognises two six-write erase sequences: one that erases the whole array and one that erases selected sectors. Once an erase sequence is complete, it runs a timed stand-in for the embedded erase. The erase first spends a preprogram-and-verify phase and then an erase phase. It raises `busy` for the whole of that time and ends with a single-cycle `erase_done` pulse.

For a sector erase, the block gathers the chosen sectors in a bitmap. It keeps collecting during an acceptance window, and every further sector command restarts that window. A suspend code inside the window is tolerated. Any other write inside the window drops the collection and returns the block to read mode. Writes that arrive while the erase runs are ignored. An asynchronous hardware reset ends any window or erase at once.

Both time spans are counted in clock cycles and set by parameters. The window length is `WIN_CYC`. The two erase phases are `PREP_CYC` and `ERASE_CYC`.

Top module: `nor_erase_cmd`

## Requirements
- R1: An active-low asynchronous `rst_n` forces `busy`, `erase_done` and `sector_map` to zero immediately, abandons any window or erase in progress, and no `erase_done` pulse follows it.
- R2: The first five writes must be, in order: data 0xAA at 0x555, data 0x55 at 0x2AA, data 0x80 at 0x555, data 0xAA at 0x555, data 0x55 at 0x2AA. Only address bits [10:0] are compared. A write with a wrong address or wrong data anywhere in writes one to six returns the block to read mode, so no sector is latched and no erase starts.
- R3: A sixth write of data 0x10 at address 0x555 starts a whole-array erase. `busy` is high in the cycle after that write's clock edge, and `sector_map` is all ones while the erase runs.
- R4: A sixth write with data 0x30 selects sector index `wr_addr[ADDR_W-1 -: SECT_W]`. That bit of `sector_map` is set from the next cycle, and the acceptance window opens.
- R5: Inside the window, further writes with data 0x30 add sectors in any order, and repeats do no harm. Each one restarts the window. `busy` rises exactly `WIN_CYC` clock edges after the edge of the last sector write, with the collected bitmap unchanged.
- R6: A write with data 0xB0 inside the window neither discards the collected sectors nor restarts the window.
- R7: A write with any data other than 0x30 or 0xB0 inside the window clears `sector_map` by the next cycle and starts no erase.
- R8: While `busy` is high, writes are ignored. `sector_map` holds, the erase length is unchanged, and no window or erase follows from them.
- R9: When the erase ends, `busy` falls, `erase_done` is high for exactly the first cycle with `busy` low, and `sector_map` reads zero.
- R10: `busy` stays high for exactly `PREP_CYC + ERASE_CYC` cycles per erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address; top SECT_W bits select a sector |
| wr_data | input | 8 | Write data byte (command code) |
| busy | output | 1 | High while the embedded erase runs |
| erase_done | output | 1 | One-cycle pulse when the erase completes |
| sector_map | output | 2**SECT_W | Sectors latched for erase |

## Verification
The bench builds the block with a 12-bit address and two sector bits, which gives four sectors. It uses a 5-cycle window and phases of 3 and 6 cycles. With only four sectors, all fifteen non-empty selections can be swept, each with idle gaps between sector writes up to the longest gap the window accepts. The 9-cycle erase is long enough to hold a complete second command sequence, so the ignore-while-busy rule is tested against a full sequence. Each of the five prefix writes is corrupted in address and, separately, in data, and the sixth write is corrupted as well.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_UL1,
      ST_UL2,
      ST_SETUP,
      ST_UL4,
      ST_UL5,
      ST_WINDOW,
      ST_ERASE
   } erase_st_e;

   localparam int unsigned KEY_ADDR_W = 11;

   localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 11'h555;
   localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 11'h2AA;

   localparam logic [7:0] DAT_KEY1    = 8'hAA;
   localparam logic [7:0] DAT_KEY2    = 8'h55;
   localparam logic [7:0] DAT_SETUP   = 8'h80;
   localparam logic [7:0] DAT_CHIP    = 8'h10;
   localparam logic [7:0] DAT_SECTOR  = 8'h30;
   localparam logic [7:0] DAT_SUSPEND = 8'hB0;

   // Successor of a prefix state once its expected write has arrived.
   function automatic erase_st_e prefix_next(input erase_st_e cur);
      case (cur)
         ST_READ:  return ST_UL1;
         ST_UL1:   return ST_UL2;
         ST_UL2:   return ST_SETUP;
         ST_SETUP: return ST_UL4;
         ST_UL4:   return ST_UL5;
         default:  return ST_READ;
      endcase
   endfunction

endpackage

// File: rtl/nor_erase_prefix.sv
module nor_erase_prefix
   import nor_erase_pkg::*;
(
   input  erase_st_e                step,
   input  logic [KEY_ADDR_W-1:0]    addr_lo,
   input  logic [7:0]               data,
   output logic                     step_hit,
   output logic                     chip_hit,
   output logic                     sector_hit
);

   logic at_a;
   logic at_b;

   assign at_a = (addr_lo == KEY_ADDR_A);
   assign at_b = (addr_lo == KEY_ADDR_B);

   always_comb begin
      case (step)
         ST_READ, ST_SETUP: step_hit = at_a && (data == DAT_KEY1);
         ST_UL1, ST_UL4:    step_hit = at_b && (data == DAT_KEY2);
         ST_UL2:            step_hit = at_a && (data == DAT_SETUP);
         default:           step_hit = 1'b0;
      endcase
   end

   assign chip_hit   = at_a && (data == DAT_CHIP);
   assign sector_hit = (data == DAT_SECTOR);

endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
   parameter int unsigned CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic zero
);

   localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [CNT_W-1:0] TOP = CNT_W'(CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= TOP;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/nor_erase_sector_dec.sv
module nor_erase_sector_dec #(
   parameter int unsigned SECT_W = 2
) (
   input  logic [SECT_W-1:0]        idx,
   output logic [(1<<SECT_W)-1:0]   hot
);

   localparam int unsigned NUM_SECT = 1 << SECT_W;

   for (genvar g = 0; g < NUM_SECT; g++) begin : g_line
      assign hot[g] = (idx == SECT_W'(g));
   end

endmodule

// File: rtl/nor_erase_cmd.sv
module nor_erase_cmd
   import nor_erase_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SECT_W    = 6,
   parameter int unsigned WIN_CYC   = 12500,
   parameter int unsigned PREP_CYC  = 1000,
   parameter int unsigned ERASE_CYC = 5000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   output logic                     busy,
   output logic                     erase_done,
   output logic [(1<<SECT_W)-1:0]   sector_map
);

   localparam int unsigned NUM_SECT = 1 << SECT_W;
   localparam int unsigned TOT_CYC  = PREP_CYC + ERASE_CYC;

   // Elaboration-time parameter checks
   if (ADDR_W < KEY_ADDR_W) begin : g_bad_addr_w
      $error("nor_erase_cmd: ADDR_W must cover the 11 key address bits");
   end
   if ((SECT_W < 1) || (SECT_W > 10) || (SECT_W > ADDR_W)) begin : g_bad_sect_w
      $error("nor_erase_cmd: SECT_W must be 1..10 and fit in ADDR_W");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("nor_erase_cmd: WIN_CYC must be at least 1");
   end
   if ((PREP_CYC < 1) || (ERASE_CYC < 1)) begin : g_bad_phase
      $error("nor_erase_cmd: both erase phases need at least one cycle");
   end

   erase_st_e             state_q, state_d;
   logic [NUM_SECT-1:0]   map_q, map_d;
   logic                  done_q, done_d;
   logic                  win_load, ers_load;
   logic                  win_zero, ers_zero;
   logic                  step_hit, chip_hit, sector_hit;
   logic [NUM_SECT-1:0]   sect_hot;

   nor_erase_prefix u_prefix (
      .step       (state_q),
      .addr_lo    (wr_addr[KEY_ADDR_W-1:0]),
      .data       (wr_data),
      .step_hit   (step_hit),
      .chip_hit   (chip_hit),
      .sector_hit (sector_hit)
   );

   nor_erase_sector_dec #(.SECT_W(SECT_W)) u_dec (
      .idx (wr_addr[ADDR_W-1 -: SECT_W]),
      .hot (sect_hot)
   );

   nor_erase_timer #(.CYC(WIN_CYC)) u_win_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (win_load),
      .run   (state_q == ST_WINDOW),
      .zero  (win_zero)
   );

   // One counter spans the preprogram and erase phases back to back.
   nor_erase_timer #(.CYC(TOT_CYC)) u_ers_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ers_load),
      .run   (state_q == ST_ERASE),
      .zero  (ers_zero)
   );

   always_comb begin
      state_d  = state_q;
      map_d    = map_q;
      done_d   = 1'b0;
      win_load = 1'b0;
      ers_load = 1'b0;
      case (state_q)
         ST_READ, ST_UL1, ST_UL2, ST_SETUP, ST_UL4: begin
            if (wr_en) begin
               state_d = step_hit ? prefix_next(state_q) : ST_READ;
            end
         end
         ST_UL5: begin
            if (wr_en) begin
               if (chip_hit) begin
                  state_d  = ST_ERASE;
                  map_d    = '1;
                  ers_load = 1'b1;
               end else if (sector_hit) begin
                  state_d  = ST_WINDOW;
                  map_d    = sect_hot;
                  win_load = 1'b1;
               end else begin
                  state_d  = ST_READ;
               end
            end
         end
         ST_WINDOW: begin
            if (wr_en && sector_hit) begin
               map_d    = map_q | sect_hot;
               win_load = 1'b1;
            end else if (wr_en && (wr_data != DAT_SUSPEND)) begin
               state_d  = ST_READ;
               map_d    = '0;
            end else if (win_zero) begin
               state_d  = ST_ERASE;
               ers_load = 1'b1;
            end
         end
         ST_ERASE: begin
            if (ers_zero) begin
               state_d = ST_READ;
               map_d   = '0;
               done_d  = 1'b1;
            end
         end
         default: begin
            state_d = ST_READ;
            map_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_READ;
         map_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         map_q   <= map_d;
         done_q  <= done_d;
      end
   end

   assign busy       = (state_q == ST_ERASE);
   assign erase_done = done_q;
   assign sector_map = map_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |=> !erase_done); // R9
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |-> (!busy && $past(busy))); // R9
   AST_MAP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sector_map)); // R8
   AST_BUSY_HAS_SECT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sector_map != '0)); // R4
   AST_CHIP_ALL_SECT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && ($past(state_q) == ST_UL5)) |-> (&sector_map)); // R3
   AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_WINDOW) && !busy) |-> (sector_map == '0)); // R7

endmodule

// File: tb/tb_nor_erase_cmd.sv
`timescale 1ns/1ps
module tb_nor_erase_cmd;

   localparam int AW   = 12;
   localparam int SW   = 2;
   localparam int NS   = 1 << SW;
   localparam int WIN  = 5;
   localparam int PREP = 3;
   localparam int ERS  = 6;
   localparam int TOT  = PREP + ERS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          busy;
   logic          erase_done;
   logic [NS-1:0] sector_map;

   nor_erase_cmd #(
      .ADDR_W(AW), .SECT_W(SW), .WIN_CYC(WIN), .PREP_CYC(PREP), .ERASE_CYC(ERS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .erase_done(erase_done), .sector_map(sector_map)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   // Output monitor, sampled at the falling edge
   int rise_cyc = -1, fall_cyc = -1, rise_cnt = 0, done_cnt = 0;
   bit done_at_fall = 1'b0;
   bit prev_busy = 1'b0;
   always @(negedge clk) begin
      if (busy && !prev_busy) begin
         rise_cyc = cyc;
         rise_cnt++;
      end
      if (!busy && prev_busy) begin
         fall_cyc = cyc;
         done_at_fall = erase_done;
      end
      if (erase_done) done_cnt++;
      prev_busy = busy;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) step();
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int t);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      t = cyc;
   endtask

   task automatic prefix();
      int t;
      wr(12'h555, 8'hAA, t);
      wr(12'h2AA, 8'h55, t);
      wr(12'h555, 8'h80, t);
      wr(12'h555, 8'hAA, t);
      wr(12'h2AA, 8'h55, t);
   endtask

   function automatic logic [AW-1:0] sa(input int g);
      return AW'((g << 10) | (10'h0F3 ^ g));
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished (%0d)", 0);
      finish_run();
   end

   initial begin
      int t, t0, r0, d0;
      logic [NS-1:0] exp_map;

      // R1: reset state
      idle(2);
      chk("R1", "busy in reset", busy, 0);
      chk("R1", "done in reset", erase_done, 0);
      chk("R1", "map in reset", sector_map, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R3, R9, R10: whole-array erase
      r0 = rise_cnt; d0 = done_cnt;
      prefix();
      wr(12'h555, 8'h10, t);
      step();
      chk("R3", "busy after chip cmd", busy, 1);
      chk("R3", "map all ones", sector_map, (1 << NS) - 1);
      idle(TOT + 2);
      chk("R3", "rise delay", rise_cyc - t, 0);
      chk("R10", "chip busy length", fall_cyc - rise_cyc, TOT);
      chk("R9", "done with fall", done_at_fall, 1);
      chk("R9", "done pulses", done_cnt - d0, 1);
      chk("R9", "map cleared", sector_map, 0);
      chk("R3", "single erase", rise_cnt - r0, 1);

      // R4, R5, R9, R10: sweep all sector selections with varying gaps
      for (int s = 1; s < (1 << NS); s++) begin
         int first;
         int gap;
         first = 0;
         while (((s >> first) & 1) == 0) first++;
         gap = s % (WIN - 1);
         r0 = rise_cnt; d0 = done_cnt;
         prefix();
         wr(sa(first), 8'h30, t);
         exp_map = NS'(1 << first);
         step();
         chk("R4", "first sector bit", sector_map, exp_map);
         for (int g = NS - 1; g >= 0; g--) begin
            if (((s >> g) & 1) != 0 && g != first) begin
               idle(gap);
               wr(sa(g), 8'h30, t);
               exp_map |= NS'(1 << g);
               step();
               chk("R5", "added sector", sector_map, exp_map);
            end
         end
         idle(gap);
         wr(sa(first), 8'h30, t);
         step();
         chk("R5", "repeat sector", sector_map, exp_map);
         idle(WIN);
         chk("R5", "busy after window", busy, 1);
         chk("R5", "map at erase", sector_map, exp_map);
         idle(TOT + 2);
         chk("R5", "window length", rise_cyc - t, WIN);
         chk("R10", "sector busy length", fall_cyc - rise_cyc, TOT);
         chk("R9", "done with fall", done_at_fall, 1);
         chk("R9", "done pulses", done_cnt - d0, 1);
         chk("R9", "map cleared", sector_map, 0);
         chk("R5", "single erase", rise_cnt - r0, 1);
      end

      // R6: suspend code in window does not abort or restart
      r0 = rise_cnt;
      prefix();
      wr(sa(1), 8'h30, t);
      wr(12'h000, 8'hB0, t0);
      step();
      chk("R6", "map kept", sector_map, 2);
      idle(WIN + TOT + 2);
      chk("R6", "window not restarted", rise_cyc - t, WIN);
      chk("R6", "erase ran", rise_cnt - r0, 1);

      // R7: other codes in the window abort
      begin
         logic [7:0] bad [5] = '{8'hF0, 8'h10, 8'hAA, 8'h80, 8'h55};
         for (int i = 0; i < 5; i++) begin
            r0 = rise_cnt;
            prefix();
            wr(sa(3), 8'h30, t);
            wr(12'h555, bad[i], t);
            step();
            chk("R7", "map cleared on abort", sector_map, 0);
            idle(WIN + TOT + 2);
            chk("R7", "no erase after abort", rise_cnt - r0, 0);
         end
      end

      // R2: corrupt each prefix write in address or data
      begin
         logic [AW-1:0] pa [5] = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA};
         logic [7:0]    pd [5] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
         for (int p = 0; p < 5; p++) begin
            for (int kind = 0; kind < 2; kind++) begin
               r0 = rise_cnt;
               for (int k = 0; k < 5; k++) begin
                  if (k == p && kind == 0) wr(pa[k], pd[k] ^ 8'h01, t);
                  else if (k == p)         wr(pa[k] ^ 12'h001, pd[k], t);
                  else                     wr(pa[k], pd[k], t);
               end
               wr(sa(2), 8'h30, t);
               step();
               chk("R2", "no sector after bad prefix", sector_map, 0);
               idle(WIN + TOT + 2);
               chk("R2", "no erase after bad prefix", rise_cnt - r0, 0);
            end
         end
         // bad sixth write: unknown code, and chip code at the wrong address
         r0 = rise_cnt;
         prefix();
         wr(12'h555, 8'h20, t);
         prefix();
         wr(12'h2AA, 8'h10, t);
         step();
         chk("R2", "map after bad sixth", sector_map, 0);
         idle(WIN + TOT + 2);
         chk("R2", "no erase after bad sixth", rise_cnt - r0, 0);
      end

      // R8: a full sector sequence during a chip erase is ignored
      r0 = rise_cnt;
      prefix();
      wr(12'h555, 8'h10, t0);
      prefix();
      wr(sa(2), 8'h30, t);
      step();
      chk("R8", "still busy", busy, 1);
      chk("R8", "map held", sector_map, (1 << NS) - 1);
      idle(WIN + TOT + 3);
      chk("R8", "length unchanged", fall_cyc - rise_cyc, TOT);
      chk("R8", "no extra erase", rise_cnt - r0, 1);
      chk("R8", "map after", sector_map, 0);

      // R1: hardware reset during an erase
      prefix();
      wr(12'h555, 8'h10, t);
      idle(3);
      chk("R1", "busy before reset", busy, 1);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1;
      chk("R1", "busy cut by reset", busy, 0);
      chk("R1", "map cut by reset", sector_map, 0);
      chk("R1", "done low in reset", erase_done, 0);
      @(negedge clk);
      #1 rst_n = 1'b1;
      d0 = done_cnt; r0 = rise_cnt;
      idle(TOT + 3);
      chk("R1", "no done after reset", done_cnt - d0, 0);
      chk("R1", "idle after reset", busy, 0);

      // R1: hardware reset during a window
      prefix();
      wr(sa(1), 8'h30, t);
      @(negedge clk);
      #1 rst_n = 1'b0;
      #1;
      chk("R1", "map cleared in window reset", sector_map, 0);
      @(negedge clk);
      #1 rst_n = 1'b1;
      idle(WIN + TOT + 2);
      chk("R1", "no erase after window reset", rise_cnt - r0, 0);

      finish_run();
   end

endmodule